// File: doc/BRIEF.md
# Column-Budgeted Challenge Selection Manager

This block decides which challenge a resistive-array PUF receives next. It is built to make model-building attacks harder. The array is split into columns. At any time, challenges come from a single column only. A column is dropped for good once a set number of challenge-response pairs from it has been exposed. Each column holds one of three states: fresh, active, or spent. When the active column runs out of budget, the block moves to a fresh column chosen from a random input. No column pair is ever handed out twice.

A requester raises `req_i` together with a random word on `rnd_i`. One cycle later the block either grants a challenge, or refuses because every column has been used up. A granted challenge appears as a column index and a row-pair index within that column. The exposure budget comes from `limit_i`, which holds its value for the life of a column. Once nothing remains to issue, `done_o` rises and stays high until reset. Turning a pair index into two row addresses, and measuring the PUF itself, happen outside this block.

Top module: `chal_sel_mgr`

## Requirements
- R1: After synchronous reset, `gnt_o` and `done_o` read 0 and every column is fresh.
- R2: A request accepted on one rising edge gives `gnt_o`=1 for exactly one cycle after that edge, with `col_o` and `pair_o` valid in that same cycle.
- R3: When no column is active, the new column is `rnd_i` modulo the column count if that column is fresh. Otherwise the block searches upward through increasing indices, wrapping from the last column to column 0, and takes the first fresh column.
- R4: Within one column the pair indices go out in order 0, 1, 2, and so on, one per grant.
- R5: A column is spent right after its (limit)-th grant, counting one grant per issued pair. A `limit_i` of 0 acts as 1, and values above the pair count ROWS*(ROWS-1)/2 (780 by default) are clamped to that count.
- R6: A spent column is never chosen again, and no (column, pair) combination is granted twice between resets.
- R7: Column states are 2-bit codes: 00 fresh, 01 active, 10 spent. At most one column is active at a time.
- R8: `done_o` rises in the same cycle as the grant that spends the last column, and it stays high until reset. While it is high, requests are refused and `gnt_o` stays 0.
- R9: A cycle with `req_i` low produces no grant in the following cycle and leaves the selection state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request for one challenge |
| rnd_i | input | RND_W (16) | Random word sampled with the request |
| limit_i | input | LIM_W (16) | Exposure budget per column, in pairs |
| gnt_o | output | 1 | One-cycle grant of a challenge |
| col_o | output | COL_W (3) | Column index of the granted challenge |
| pair_o | output | PAIR_W (10) | Row-pair index within the column |
| done_o | output | 1 | All columns spent; requests refused |

## Verification
Several kinds of fault would show up in the port sequence within one grant. A wrong column state shows up as a revisited column or a skipped fresh column. A wrong pair counter shows up as a gap or a repeat in `pair_o`. Both appear on the next grant after the fault. A wrong budget comparison shows up as a column change one grant too early or too late. A fault in the done logic changes the total number of grants before `done_o`, which should be exactly the column count times the clamped limit. The bench keeps its own state model and compares every cycle. A fault is therefore reported in the first cycle where it reaches `gnt_o`, `col_o`, `pair_o` or `done_o`.

// File: rtl/chal_sel_pkg.sv
package chal_sel_pkg;
  typedef enum logic [1:0] {
    COL_FRESH  = 2'b00,
    COL_ACTIVE = 2'b01,
    COL_SPENT  = 2'b10
  } col_state_t;
endpackage

// File: rtl/chal_col_table.sv
module chal_col_table
  import chal_sel_pkg::*;
#(
  parameter int COLS  = 8,
  parameter int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             claim_en,
  input  logic [COL_W-1:0] claim_idx,
  input  logic             retire_en,
  input  logic [COL_W-1:0] retire_idx,
  output logic [COLS-1:0]  fresh_vec,
  output logic [COLS-1:0]  active_vec
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    col_state_t st;
    always_ff @(posedge clk) begin
      if (rst) begin
        st <= COL_FRESH;
      end else if (retire_en && retire_idx == COL_W'(c)) begin
        st <= COL_SPENT;
      end else if (claim_en && claim_idx == COL_W'(c)) begin
        st <= COL_ACTIVE;
      end
    end
    assign fresh_vec[c]  = (st == COL_FRESH);
    assign active_vec[c] = (st == COL_ACTIVE);
  end
endmodule

// File: rtl/chal_col_picker.sv
module chal_col_picker #(
  parameter int COLS  = 8,
  parameter int COL_W = $clog2(COLS),
  parameter int RND_W = 16
) (
  input  logic [RND_W-1:0] rnd_i,
  input  logic [COLS-1:0]  fresh_vec,
  output logic [COL_W-1:0] pick_idx,
  output logic             pick_ok
);
  logic [RND_W-1:0] start;
  assign start = rnd_i % RND_W'(COLS);

  always_comb begin
    pick_idx = '0;
    pick_ok  = 1'b0;
    // walk downward so the nearest upward candidate is written last
    for (int k = COLS - 1; k >= 0; k--) begin
      int idx;
      idx = int'(start) + k;
      if (idx >= COLS) idx = idx - COLS;
      if (fresh_vec[idx]) begin
        pick_idx = COL_W'(idx);
        pick_ok  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chal_sel_mgr.sv
module chal_sel_mgr #(
  parameter int COLS  = 8,
  parameter int ROWS  = 40,
  parameter int RND_W = 16,
  parameter int LIM_W = 16,
  parameter int COL_W = $clog2(COLS),
  parameter int PAIR_W = $clog2(ROWS * (ROWS - 1) / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [RND_W-1:0]  rnd_i,
  input  logic [LIM_W-1:0]  limit_i,
  output logic              gnt_o,
  output logic [COL_W-1:0]  col_o,
  output logic [PAIR_W-1:0] pair_o,
  output logic              done_o
);
  localparam int MAX_PAIRS = ROWS * (ROWS - 1) / 2;
  localparam int CNT_W     = PAIR_W + 1;

  logic              act_valid;
  logic [COL_W-1:0]  act_col;
  logic [PAIR_W-1:0] pair_cnt;
  logic [COLS-1:0]   fresh_vec, active_vec, fresh_after;
  logic [COL_W-1:0]  pick_idx, cur_col;
  logic              pick_ok, issue, last, act_next, done_next;
  logic [PAIR_W-1:0] cur_pair;
  logic [CNT_W-1:0]  lim_eff;

  chal_col_table #(.COLS(COLS), .COL_W(COL_W)) u_table (
    .clk, .rst,
    .claim_en  (issue && !act_valid),
    .claim_idx (pick_idx),
    .retire_en (issue && last),
    .retire_idx(cur_col),
    .fresh_vec, .active_vec
  );

  chal_col_picker #(.COLS(COLS), .COL_W(COL_W), .RND_W(RND_W)) u_pick (
    .rnd_i, .fresh_vec, .pick_idx, .pick_ok
  );

  always_comb begin
    if (limit_i == '0)                          lim_eff = CNT_W'(1);
    else if (limit_i > LIM_W'(MAX_PAIRS))       lim_eff = CNT_W'(MAX_PAIRS);
    else                                        lim_eff = CNT_W'(limit_i);
  end

  assign issue    = req_i && !done_o && (act_valid || pick_ok);
  assign cur_col  = act_valid ? act_col : pick_idx;
  assign cur_pair = act_valid ? pair_cnt : '0;
  assign last     = (CNT_W'(cur_pair) + CNT_W'(1)) >= lim_eff;
  assign act_next = issue ? !last : act_valid;

  always_comb begin
    fresh_after = fresh_vec;
    if (issue && !act_valid) fresh_after[pick_idx] = 1'b0;
  end
  assign done_next = (fresh_after == '0) && !act_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid <= 1'b0;
      act_col   <= '0;
      pair_cnt  <= '0;
      gnt_o     <= 1'b0;
      col_o     <= '0;
      pair_o    <= '0;
      done_o    <= 1'b0;
    end else begin
      gnt_o <= issue;
      if (issue) begin
        act_valid <= !last;
        act_col   <= cur_col;
        pair_cnt  <= cur_pair + PAIR_W'(1);
        col_o     <= cur_col;
        pair_o    <= cur_pair;
      end
      done_o <= done_o || done_next;
    end
  end
endmodule

// File: rtl/chal_sel_chk.sv
module chal_sel_chk #(
  parameter int COLS   = 8,
  parameter int COL_W  = 3,
  parameter int PAIR_W = 10,
  parameter int MAX_PAIRS = 780
) (
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic              gnt_o,
  input logic [COL_W-1:0]  col_o,
  input logic [PAIR_W-1:0] pair_o,
  input logic              done_o,
  input logic [COLS-1:0]   active_vec
);
  logic              seen;
  logic [COL_W-1:0]  prev_col;
  logic [PAIR_W-1:0] prev_pair;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0; prev_col <= '0; prev_pair <= '0;
    end else if (gnt_o) begin
      seen <= 1'b1; prev_col <= col_o; prev_pair <= pair_o;
    end
  end

  // R2
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_o |-> $past(req_i));
  // R9
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !gnt_o);
  // R7
  single_active_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(active_vec));
  // R4
  pair_step_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o && seen && col_o == prev_col) |-> (pair_o == prev_pair + PAIR_W'(1)));
  // R4
  pair_start_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_o && (!seen || col_o != prev_col)) |-> (pair_o == '0));
  // R5
  pair_range_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_o |-> (pair_o < PAIR_W'(MAX_PAIRS)));
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
  // R8
  done_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !gnt_o);
endmodule

bind chal_sel_mgr chal_sel_chk #(
  .COLS(COLS), .COL_W(COL_W), .PAIR_W(PAIR_W), .MAX_PAIRS(MAX_PAIRS)
) u_chk (
  .clk, .rst, .req_i, .gnt_o, .col_o, .pair_o, .done_o, .active_vec
);

// File: tb/chal_sel_mgr_tb.sv
module chal_sel_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 8;
  localparam int ROWS = 40;
  localparam int MAXP = ROWS * (ROWS - 1) / 2;

  logic        clk = 0, rst = 1, req_i = 0;
  logic [15:0] rnd_i = 0, limit_i = 0;
  logic        gnt_o, done_o;
  logic [2:0]  col_o;
  logic [9:0]  pair_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  // bench model
  int  m_st[COLS];     // 0 fresh, 1 active, 2 spent
  bit  m_act;
  int  m_col, m_cnt, m_grants;
  bit  m_done;
  bit  used[COLS][MAXP];

  always #(CLK_PERIOD/2) clk = ~clk;

  chal_sel_mgr u_dut (.clk, .rst, .req_i, .rnd_i, .limit_i,
                      .gnt_o, .col_o, .pair_o, .done_o);

  function automatic int clamp_lim(input int l);
    if (l == 0) return 1;
    if (l > MAXP) return MAXP;
    return l;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < COLS; c++) begin
      m_st[c] = 0;
      for (int p = 0; p < MAXP; p++) used[c][p] = 0;
    end
    m_act = 0; m_col = 0; m_cnt = 0; m_done = 0; m_grants = 0;
  endtask

  task automatic do_reset();
    rst = 1; req_i = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    model_reset();
    // R1
    chk(gnt_o == 0, "R1 gnt after reset", gnt_o, 0);
    chk(done_o == 0, "R1 done after reset", done_o, 0);
  endtask

  task automatic step(input bit r, input logic [15:0] rv);
    bit e_gnt; int e_col, e_pair, lim;
    e_gnt = 0; e_col = 0; e_pair = 0;
    lim = clamp_lim(int'(limit_i));
    if (r && !m_done) begin
      if (!m_act) begin
        int s; s = int'(rv) % COLS;
        for (int k = 0; k < COLS; k++) begin
          int idx; idx = (s + k) % COLS;
          if (m_st[idx] == 0 && !m_act) begin
            m_act = 1; m_col = idx; m_cnt = 0; m_st[idx] = 1;
          end
        end
      end
      if (m_act) begin
        e_gnt = 1; e_col = m_col; e_pair = m_cnt;
        m_cnt++; m_grants++;
        if (m_cnt >= lim) begin m_st[m_col] = 2; m_act = 0; end
        begin
          bit any; any = 0;
          for (int c = 0; c < COLS; c++) if (m_st[c] == 0) any = 1;
          if (!any && !m_act) m_done = 1;
        end
      end
    end
    req_i = r; rnd_i = rv;
    @(posedge clk); @(negedge clk);
    req_i = 0;
    // R2 R9 R8
    chk(gnt_o == e_gnt, r ? "R2 grant" : "R9 idle", gnt_o, e_gnt);
    if (gnt_o && e_gnt) begin
      // R3 R6 column choice
      chk(col_o == e_col, "R3 column", col_o, e_col);
      // R4 sequential pair
      chk(pair_o == e_pair, "R4 pair", pair_o, e_pair);
      // R6 uniqueness
      chk(!used[col_o][pair_o], "R6 repeat", 1, 0);
      used[col_o][pair_o] = 1;
    end
    chk(done_o == m_done, "R8 done", done_o, m_done);
  endtask

  task automatic run_until_done(input int lim, input bit fixed_rnd, input logic [15:0] frv);
    while (!m_done) begin
      bit r; r = ($urandom % 10) < 8;
      step(r, fixed_rnd ? frv : 16'($urandom));
    end
    // R5 total grants equals column count times clamped budget
    chk(m_grants == COLS * clamp_lim(lim), "R5 total grants", m_grants, COLS * clamp_lim(lim));
    // R8 refused afterwards
    for (int i = 0; i < 4; i++) step(1, 16'($urandom));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    limit_i = 16'd3;
    do_reset();
    // R9 idle cycles before any request
    step(0, 16'd5); step(0, 16'd2);
    run_until_done(3, 0, 0);

    // R3 wrap-around: budget 0 acts as 1, rnd always points to last column
    limit_i = 16'd0;
    do_reset();
    run_until_done(0, 1, 16'd7);

    // R5 budget above capacity is clamped
    limit_i = 16'd2000;
    do_reset();
    run_until_done(2000, 0, 0);

    // R3 mod of large random word, budget 5
    limit_i = 16'd5;
    do_reset();
    step(1, 16'hFFFF);
    run_until_done(5, 0, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule